// File: doc/BRIEF.md
# Optical-Disc Read Status and Interrupt Logic

This block holds the status of the sector or frame that the read channel of an optical-disc controller is working on, and drives the interrupt line to the local microcontroller. The decoding pipeline sends it single-cycle event pulses. These report that a sync pattern was seen, that header reception started or finished, that a Q-channel subcode byte arrived, the result of the Q-channel CRC, a subcode gap, and the end of a frame. Each end-of-frame pulse comes with three result levels: sync good, data good and CRC good.

At every end of frame the block assembles one status byte from its live flags and the three results. It places that byte on a register output and raises a one-cycle write request, so the buffer controller stores the byte next to the frame data. The register keeps the byte until the next frame ends, which lets the microcontroller read the same value. The result bits exist only inside this snapshot.

Between frames the block tracks whether a header or a full Q-channel frame is waiting to be read, and whether the header or the Q-channel data was bad. Host reads of header or Q-channel bytes, sync patterns, subcode gaps and frame ends clear these flags. In data mode the header flags drive the interrupt and the storage inhibit. In audio mode the Q-channel flags drive them.

Top module: `rdstat_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every flag is cleared. After that edge `stat_reg` is 0, and `stat_wr`, `irq` and `store_inh` are 0.
- R2: An `eof` pulse makes `stat_wr` high for exactly the following cycle. From that same cycle, `stat_reg` holds the snapshot taken at that edge. `stat_reg` does not change at any other time. Bit layout: 7 decoder active, 6 bad Q, 5 Q frame ready, 4 header ready, 3 header error, 2 CRC error, 1 data error, 0 sync error.
- R3: Snapshot bits 2, 1 and 0 are the inverses of `crc_good`, `data_good` and `sync_good` sampled with `eof`, so 0 means a good result. Bit 7 is `xfer_active` sampled with `eof`. Bits 6 to 3 are the flag values just before that edge.
- R4: `hdr_done` sets header ready in the next cycle. A `rd_hdr` strobe with `rd_idx` 0 to 3 clears it. A `rd_hdr` strobe with `rd_idx` of 4 or more has no effect.
- R5: An end of frame does not clear header ready. It stays set until a read clears it (R4) or `sync_det` arrives. If `hdr_done` and a clearing event fall in the same cycle, header ready is set.
- R6: Header error takes the value of `hdr_bad` at each `hdr_done`. It clears on `hdr_start`.
- R7: Q frame ready sets in the cycle after the tenth `q_byte` of a frame. `eof` clears it and restarts the byte count, and a `q_byte` in the same cycle as `eof` is dropped. A `rd_q` strobe with `rd_idx` 0 to 9 clears it. A `rd_q` strobe with `rd_idx` of 10 or more has no effect.
- R8: A `q_crc_valid` pulse with `q_crc_ok` low sets bad Q. While `xfer_active` is high, a good Q CRC or an `eof` clears bad Q. While `xfer_active` is low, only `gap_det` clears it, and a good Q CRC or an `eof` leaves it set. A failing Q CRC wins over any clear in the same cycle.
- R9: `irq` equals header ready when `data_mode` is 1 and Q frame ready when `data_mode` is 0.
- R10: `store_inh` is high only when `auto_store` is 1 and either `data_mode` is 1 with header error set, or `data_mode` is 0 with bad Q set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| data_mode | input | 1 | 1 = data mode, 0 = audio mode |
| auto_store | input | 1 | Automatic storage enable |
| xfer_active | input | 1 | Decoder is shifting data into the buffer |
| sync_det | input | 1 | Sync pattern detected (pulse) |
| hdr_start | input | 1 | Header reception begins (pulse) |
| hdr_done | input | 1 | Header complete (pulse) |
| hdr_bad | input | 1 | Header had errors, valid with `hdr_done` |
| q_byte | input | 1 | One Q-channel byte received (pulse) |
| q_crc_valid | input | 1 | Q-channel CRC result available (pulse) |
| q_crc_ok | input | 1 | Q-channel CRC passed, valid with `q_crc_valid` |
| gap_det | input | 1 | Subcode gap detected (pulse) |
| eof | input | 1 | End of frame (pulse) |
| sync_good | input | 1 | Frame sync result, valid with `eof` |
| data_good | input | 1 | Frame data result, valid with `eof` |
| crc_good | input | 1 | Frame CRC result, valid with `eof` |
| rd_hdr | input | 1 | Host read of a header byte (strobe) |
| rd_q | input | 1 | Host read of a Q-channel byte (strobe) |
| rd_idx | input | 4 | Byte index for `rd_hdr` / `rd_q` |
| stat_reg | output | 8 | Status byte of the last frame |
| stat_wr | output | 1 | Request to write `stat_reg` to the buffer |
| store_inh | output | 1 | Inhibit automatic storage |
| irq | output | 1 | Interrupt to the microcontroller (level) |

## Verification
The bench targets the clear rules of the flags, because a wrong rule there still leaves a plausible-looking design. If header ready were cleared at the end of a frame, an unread header would be lost before the next sync; if an out-of-range index still cleared a flag, reads of unrelated bytes would drop the interrupt. Bad Q is driven through both decoder states: a design that ignored `xfer_active` would release the audio storage inhibit on a good CRC or a frame end, where only a gap may release it. The snapshot is checked for the inverted result bits, for the pre-clear flag values, and for holding its value between frames. A count that missed the tenth Q byte, or that never restarted at a frame end, would leave the audio interrupt stuck or never raise it.

// File: rtl/rdstat_pkg.sv
// Shared definitions for the read status block.
// Assumes: the status byte layout below is decoded by software and by the
// buffer controller, so its field order is fixed.
package rdstat_pkg;

    // Status byte, most significant field first.
    typedef struct packed {
        logic dec_act;   // bit 7: decoder shifting data into the buffer
        logic bad_q;     // bit 6: Q-channel CRC failed
        logic qfrm_rdy;  // bit 5: all Q-channel bytes received
        logic hdr_rdy;   // bit 4: header waiting to be read
        logic hdr_err;   // bit 3: header received with errors
        logic crc_err;   // bit 2: frame CRC failed
        logic dat_err;   // bit 1: frame data uncorrectable
        logic syn_err;   // bit 0: frame sync missing
    } rd_status_t;

endpackage

// File: rtl/hdr_track.sv
// Header flag tracker.
// Keeps header-ready and header-error. Header-ready persists over frame ends
// until a header byte read or a sync pattern; a completing header wins over
// any clear in the same cycle.
// Assumes: all event inputs are single-cycle pulses on clk.
module hdr_track #(
    parameter int HDR_BYTES = 4,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_det,
    input  logic             hdr_start,
    input  logic             hdr_done,
    input  logic             hdr_bad,
    input  logic             rd_hdr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             hdr_rdy,
    output logic             hdr_err
);

    localparam logic [IDX_W-1:0] HDR_LIM = IDX_W'(HDR_BYTES);

    logic rd_hit;

    // Host read that addresses a header byte.
    always_comb rd_hit = rd_hdr && (rd_idx < HDR_LIM);

    // Header-ready: set on completion, clear on read or sync.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hdr_rdy <= 1'b0;
        else if (hdr_done)
            hdr_rdy <= 1'b1;
        else if (rd_hit || sync_det)
            hdr_rdy <= 1'b0;
    end

    // Header-error: captured on completion, dropped when the next header starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hdr_err <= 1'b0;
        else if (hdr_done)
            hdr_err <= hdr_bad;
        else if (hdr_start)
            hdr_err <= 1'b0;
    end

    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |=> hdr_rdy);
    a_r4_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hdr && rd_idx < HDR_LIM && !hdr_done) |=> !hdr_rdy);
    a_r5_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_det && !hdr_done) |=> !hdr_rdy);
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_rdy && !rd_hdr && !sync_det) |=> hdr_rdy);
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |=> (hdr_err == $past(hdr_bad)));
    a_r6_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_start && !hdr_done) |=> !hdr_err);

endmodule

// File: rtl/qchan_track.sv
// Q-channel flag tracker.
// Counts Q-channel bytes within a frame, raises Q-frame-ready on the last one
// and keeps bad-Q, whose clear rule depends on whether the decoder is active.
// Assumes: event inputs are single-cycle pulses; byte count restarts at eof.
module qchan_track #(
    parameter int QBYTES = 10,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_active,
    input  logic             eof,
    input  logic             q_byte,
    input  logic             q_crc_valid,
    input  logic             q_crc_ok,
    input  logic             gap_det,
    input  logic             rd_q,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             qfrm_rdy,
    output logic             bad_q
);

    localparam int               CW    = $clog2(QBYTES + 1);
    localparam logic [CW-1:0]    LAST  = CW'(QBYTES - 1);
    localparam logic [CW-1:0]    FULL  = CW'(QBYTES);
    localparam logic [IDX_W-1:0] Q_LIM = IDX_W'(QBYTES);

    logic [CW-1:0] cnt;
    logic          rd_hit;

    // Host read that addresses a Q-channel byte.
    always_comb rd_hit = rd_q && (rd_idx < Q_LIM);

    // Byte counter and Q-frame-ready; eof restarts the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            qfrm_rdy <= 1'b0;
        end else if (eof) begin
            cnt      <= '0;
            qfrm_rdy <= 1'b0;
        end else begin
            if (q_byte && cnt != FULL)
                cnt <= cnt + 1'b1;
            if (q_byte && cnt == LAST)
                qfrm_rdy <= 1'b1;
            else if (rd_hit)
                qfrm_rdy <= 1'b0;
        end
    end

    // Bad-Q: fail sets; clear source depends on decoder activity.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bad_q <= 1'b0;
        else if (q_crc_valid && !q_crc_ok)
            bad_q <= 1'b1;
        else if (xfer_active && (eof || q_crc_valid))
            bad_q <= 1'b0;
        else if (!xfer_active && gap_det)
            bad_q <= 1'b0;
    end

    a_r7_eof_clear: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> !qfrm_rdy);
    a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && rd_idx < Q_LIM && !q_byte && !eof) |=> !qfrm_rdy);
    a_r8_fail_set: assert property (@(posedge clk) disable iff (!rst_n)
        (q_crc_valid && !q_crc_ok) |=> bad_q);
    a_r8_audio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_q && !xfer_active && !gap_det) |=> bad_q);

endmodule

// File: rtl/frame_snap.sv
// Frame status snapshot.
// Latches the live status byte at every end of frame and requests a buffer
// write of it in the following cycle; the latched byte is the readable copy.
// Assumes: eof is a single-cycle pulse.
module frame_snap (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   eof,
    input  rdstat_pkg::rd_status_t live,
    output logic [7:0]             stat_reg,
    output logic                   stat_wr
);

    // Snapshot register and write request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_reg <= 8'h00;
            stat_wr  <= 1'b0;
        end else begin
            stat_wr <= eof;
            if (eof)
                stat_reg <= live;
        end
    end

    a_r2_write: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> stat_wr);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !eof |=> $stable(stat_reg));

endmodule

// File: rtl/rdstat_ctrl.sv
// Read status and interrupt logic, top level.
// Combines the header and Q-channel trackers with the per-frame snapshot and
// selects the interrupt and storage inhibit by mode.
// Assumes: one clock, synchronous active-low reset, pulse-type event inputs.
module rdstat_ctrl #(
    parameter int HDR_BYTES = 4,
    parameter int QBYTES    = 10,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_mode,
    input  logic             auto_store,
    input  logic             xfer_active,
    input  logic             sync_det,
    input  logic             hdr_start,
    input  logic             hdr_done,
    input  logic             hdr_bad,
    input  logic             q_byte,
    input  logic             q_crc_valid,
    input  logic             q_crc_ok,
    input  logic             gap_det,
    input  logic             eof,
    input  logic             sync_good,
    input  logic             data_good,
    input  logic             crc_good,
    input  logic             rd_hdr,
    input  logic             rd_q,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       stat_reg,
    output logic             stat_wr,
    output logic             store_inh,
    output logic             irq
);

    import rdstat_pkg::*;

    logic       hdr_rdy, hdr_err, qfrm_rdy, bad_q;
    rd_status_t live;

    hdr_track #(.HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_det (sync_det),
        .hdr_start(hdr_start),
        .hdr_done (hdr_done),
        .hdr_bad  (hdr_bad),
        .rd_hdr   (rd_hdr),
        .rd_idx   (rd_idx),
        .hdr_rdy  (hdr_rdy),
        .hdr_err  (hdr_err)
    );

    qchan_track #(.QBYTES(QBYTES), .IDX_W(IDX_W)) u_qch (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_active(xfer_active),
        .eof        (eof),
        .q_byte     (q_byte),
        .q_crc_valid(q_crc_valid),
        .q_crc_ok   (q_crc_ok),
        .gap_det    (gap_det),
        .rd_q       (rd_q),
        .rd_idx     (rd_idx),
        .qfrm_rdy   (qfrm_rdy),
        .bad_q      (bad_q)
    );

    // Live status byte presented to the snapshot.
    always_comb begin
        live.dec_act  = xfer_active;
        live.bad_q    = bad_q;
        live.qfrm_rdy = qfrm_rdy;
        live.hdr_rdy  = hdr_rdy;
        live.hdr_err  = hdr_err;
        live.crc_err  = !crc_good;
        live.dat_err  = !data_good;
        live.syn_err  = !sync_good;
    end

    frame_snap u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .eof     (eof),
        .live    (live),
        .stat_reg(stat_reg),
        .stat_wr (stat_wr)
    );

    // Mode-selected interrupt and storage inhibit.
    always_comb begin
        irq       = data_mode ? hdr_rdy : qfrm_rdy;
        store_inh = auto_store && (data_mode ? hdr_err : bad_q);
    end

    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (stat_reg == 8'h00 && !stat_wr && !irq && !store_inh));
    a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (!stat_wr || $past(eof)));
    a_r10_off: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_store |-> !store_inh);

endmodule

// File: tb/test_rdstat_ctrl.sv
`timescale 1ns/1ps
module test_rdstat_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_mode = 1'b0, auto_store = 1'b0, xfer_active = 1'b0;
    logic       sync_det = 1'b0, hdr_start = 1'b0, hdr_done = 1'b0, hdr_bad = 1'b0;
    logic       q_byte = 1'b0, q_crc_valid = 1'b0, q_crc_ok = 1'b0, gap_det = 1'b0;
    logic       eof = 1'b0, sync_good = 1'b0, data_good = 1'b0, crc_good = 1'b0;
    logic       rd_hdr = 1'b0, rd_q = 1'b0;
    logic [3:0] rd_idx = 4'd0;
    logic [7:0] stat_reg;
    logic       stat_wr, store_inh, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rdstat_ctrl i_rdstat_ctrl (
        .clk(clk), .rst_n(rst_n), .data_mode(data_mode), .auto_store(auto_store),
        .xfer_active(xfer_active), .sync_det(sync_det), .hdr_start(hdr_start),
        .hdr_done(hdr_done), .hdr_bad(hdr_bad), .q_byte(q_byte),
        .q_crc_valid(q_crc_valid), .q_crc_ok(q_crc_ok), .gap_det(gap_det),
        .eof(eof), .sync_good(sync_good), .data_good(data_good),
        .crc_good(crc_good), .rd_hdr(rd_hdr), .rd_q(rd_q), .rd_idx(rd_idx),
        .stat_reg(stat_reg), .stat_wr(stat_wr), .store_inh(store_inh), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic end_frame(input logic sg, input logic dg, input logic cg);
        eof = 1'b1; sync_good = sg; data_good = dg; crc_good = cg;
        step();
        eof = 1'b0;
    endtask

    task automatic header(input logic bad);
        hdr_done = 1'b1; hdr_bad = bad;
        step();
        hdr_done = 1'b0; hdr_bad = 1'b0;
    endtask

    task automatic read_hdr(input logic [3:0] idx);
        rd_hdr = 1'b1; rd_idx = idx;
        step();
        rd_hdr = 1'b0;
    endtask

    task automatic read_q(input logic [3:0] idx);
        rd_q = 1'b1; rd_idx = idx;
        step();
        rd_q = 1'b0;
    endtask

    task automatic qbytes(input int n);
        for (int i = 0; i < n; i++) begin
            q_byte = 1'b1;
            step();
            q_byte = 1'b0;
        end
    endtask

    task automatic qcrc(input logic ok);
        q_crc_valid = 1'b1; q_crc_ok = ok;
        step();
        q_crc_valid = 1'b0;
    endtask

    task automatic pulse_sync();
        sync_det = 1'b1;
        step();
        sync_det = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 stat_reg", stat_reg, 8'h00);
        chk("R1 stat_wr", {7'd0, stat_wr}, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 store_inh", {7'd0, store_inh}, 8'h00);
    endtask

    task automatic t_frame();
        xfer_active = 1'b1;
        end_frame(1'b0, 1'b1, 1'b0);
        chk("R2 stat_wr pulse", {7'd0, stat_wr}, 8'h01);
        chk("R3 result bits and decoder bit", stat_reg, 8'h85);
        xfer_active = 1'b0;
        step();
        chk("R2 stat_wr one cycle", {7'd0, stat_wr}, 8'h00);
        chk("R2 stat_reg holds", stat_reg, 8'h85);
        end_frame(1'b1, 1'b1, 1'b1);
        chk("R3 all good", stat_reg, 8'h00);
    endtask

    task automatic t_header();
        data_mode = 1'b1;
        header(1'b0);
        chk("R4 set / R9 irq data mode", {7'd0, irq}, 8'h01);
        read_hdr(4'd5);
        chk("R4 out-of-range read ignored", {7'd0, irq}, 8'h01);
        end_frame(1'b1, 1'b1, 1'b1);
        chk("R3 header ready in snapshot", stat_reg, 8'h10);
        chk("R5 survives eof", {7'd0, irq}, 8'h01);
        read_hdr(4'd2);
        chk("R4 read clears", {7'd0, irq}, 8'h00);
        header(1'b0);
        pulse_sync();
        chk("R5 sync clears", {7'd0, irq}, 8'h00);
        hdr_done = 1'b1; sync_det = 1'b1;
        step();
        hdr_done = 1'b0; sync_det = 1'b0;
        chk("R5 set wins over sync", {7'd0, irq}, 8'h01);
        pulse_sync();
    endtask

    task automatic t_hdr_err();
        data_mode = 1'b1; auto_store = 1'b1;
        header(1'b1);
        chk("R6 error captured / R10 inhibit", {7'd0, store_inh}, 8'h01);
        end_frame(1'b1, 1'b1, 1'b1);
        chk("R3 header flags in snapshot", stat_reg, 8'h18);
        auto_store = 1'b0;
        step();
        chk("R10 no inhibit without auto store", {7'd0, store_inh}, 8'h00);
        auto_store = 1'b1;
        hdr_start = 1'b1;
        step();
        hdr_start = 1'b0;
        chk("R6 cleared on header start", {7'd0, store_inh}, 8'h00);
        auto_store = 1'b0;
        pulse_sync();
    endtask

    task automatic t_qframe();
        data_mode = 1'b0;
        qbytes(9);
        chk("R7 not ready after nine bytes", {7'd0, irq}, 8'h00);
        qbytes(1);
        chk("R7 ready after ten / R9 audio irq", {7'd0, irq}, 8'h01);
        data_mode = 1'b1;
        step();
        chk("R9 data mode selects header flag", {7'd0, irq}, 8'h00);
        data_mode = 1'b0;
        read_q(4'd12);
        chk("R7 out-of-range read ignored", {7'd0, irq}, 8'h01);
        read_q(4'd9);
        chk("R7 read clears", {7'd0, irq}, 8'h00);
        end_frame(1'b1, 1'b1, 1'b1);
        qbytes(10);
        chk("R7 count restarts after eof", {7'd0, irq}, 8'h01);
        end_frame(1'b1, 1'b1, 1'b1);
        chk("R3 Q ready in snapshot", stat_reg, 8'h20);
        chk("R7 eof clears", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_badq_active();
        data_mode = 1'b0; auto_store = 1'b1; xfer_active = 1'b1;
        qcrc(1'b0);
        chk("R8 fail sets / R10 audio inhibit", {7'd0, store_inh}, 8'h01);
        qcrc(1'b1);
        chk("R8 good CRC clears while active", {7'd0, store_inh}, 8'h00);
        qcrc(1'b0);
        end_frame(1'b1, 1'b1, 1'b1);
        chk("R3 bad Q and decoder bit in snapshot", stat_reg, 8'hC0);
        chk("R8 eof clears while active", {7'd0, store_inh}, 8'h00);
        xfer_active = 1'b0;
    endtask

    task automatic t_badq_idle();
        data_mode = 1'b0; auto_store = 1'b1; xfer_active = 1'b0;
        qcrc(1'b0);
        end_frame(1'b1, 1'b1, 1'b1);
        chk("R3 bad Q in snapshot", stat_reg, 8'h40);
        chk("R8 eof keeps bad Q when idle", {7'd0, store_inh}, 8'h01);
        qcrc(1'b1);
        chk("R8 good CRC keeps bad Q when idle", {7'd0, store_inh}, 8'h01);
        gap_det = 1'b1;
        step();
        gap_det = 1'b0;
        chk("R8 gap clears when idle", {7'd0, store_inh}, 8'h00);
        auto_store = 1'b0;
    endtask

    initial begin
        step();
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_frame();
        t_header();
        t_hdr_err();
        t_qframe();
        t_badq_active();
        t_badq_idle();
        rst_n = 1'b0;
        step();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule